// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Core

This block is a small single-port word memory with registered address and control. Each rising clock edge samples one access request. A request is a read, a write or a deselected cycle. The decision depends on three chip selects, a global write strobe, a byte-write function strobe and one write strobe per byte lane. Every data word is two 9-bit lanes. Lane 0 is bits 8:0 and lane 1 is bits 17:9. Each lane holds 8 data bits and 1 parity bit, and the memory stores all 9 bits of a lane alike.

Writes are committed to the array at the same edge that samples them. Reads pass through two register stages. The first stage is a state register holding the classified request and its address. The second stage is the output data register. A read sampled at edge E is therefore visible after edge E+1.

The first stage is kept as a small state machine with three states:
- `ST_DESEL`: the device was not selected.
- `ST_READ`: a read is waiting for the array.
- `ST_WRITE`: a write was committed.

Every edge moves the machine from its present state to one of these three states, chosen only by the newly sampled request:
- A deselect moves it to `ST_DESEL`.
- A write moves it to `ST_WRITE`.
- A read moves it to `ST_READ`.

The data register loads only when the machine is in `ST_READ`. The valid flag follows the state one edge later, so a deselect or write removes valid data after one cycle.

An output enable gates the data and valid outputs combinationally. It does not disturb the pipeline.

Top module: `pss_core`

## Requirements
- R1: While reset is asserted and after its release, with no read completed, `rvalid` is 0 and `rdata` is 0 (with `oe_n` = 0).
- R2: The device is selected only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Any other combination writes nothing and returns no read data.
- R3: When selected with `gwr_n`=0, both lanes of the addressed word are written with `wdata`, whatever the values of `bwfn_n` and `lane_wr_n`.
- R4: When selected with `gwr_n`=1 and `bwfn_n`=0, each lane whose `lane_wr_n` bit is 0 is written and each other lane keeps its contents. Bit i of `lane_wr_n` controls lane i.
- R5: When selected with `gwr_n`=1, and either `bwfn_n`=1 or `lane_wr_n`=2'b11, the cycle is a read and the array is not modified.
- R6: A read sampled at edge E shows the addressed word on `rdata`, with `rvalid`=1, from edge E+1 until edge E+2. Reads sampled on consecutive edges stream one word per cycle.
- R7: A deselect or write cycle sampled at edge E drives `rvalid` to 0 from edge E+1.
- R8: `rdata` keeps the last word read while no read completes.
- R9: `oe_n`=1 forces `rdata` and `rvalid` to 0 immediately, without changing the pipeline contents. Lowering `oe_n` again restores them.
- R10: A word written at edge E is returned by a read of the same address sampled at edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| gwr_n | input | 1 | Global write, active low, writes all lanes |
| bwfn_n | input | 1 | Byte-write function enable, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANE_W*LANES | Write data |
| rdata | output | LANE_W*LANES | Read data, zero when output disabled |
| rvalid | output | 1 | Read data valid in this cycle |

## Verification
The embedded assertions watch the pipeline timing on every cycle. They check the following:
- A first-stage read always sets the valid flag one edge later, and any other state clears it.
- The data register stays unchanged when no read reaches it.
- A deselected request never produces a read.
- A read never follows a cycle that drove a lane write.
- The output enable blanks both outputs.

Only the bench's scenarios can show what the array holds. These include lane merging under partial writes, the global-write override of the lane strobes, the absence of writes for each chip-select combination that deselects, and read-after-write returning the new word.

// File: rtl/pss_pkg.sv
`timescale 1ns/1ps
package pss_pkg;
    // Classification of the request held in the first pipeline stage
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } stage_e;
endpackage

// File: rtl/pss_ctrl.sv
`timescale 1ns/1ps
module pss_ctrl
    import pss_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              gwr_n,
    input  logic              bwfn_n,
    input  logic [LANES-1:0]  lane_wr_n,
    output logic [LANES-1:0]  wr_mask,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              out_live
);
    stage_e            state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              live_q;
    logic              sel_any;

    assign sel_any = !sel0_n && sel1 && !sel2_n;

    // Request decode: next state and write lanes
    always_comb begin
        state_d = ST_READ;
        wr_mask = '0;
        if (!sel_any) begin
            state_d = ST_DESEL;
        end else if (!gwr_n) begin
            state_d = ST_WRITE;
            wr_mask = '1;
        end else if (!bwfn_n && (lane_wr_n != '1)) begin
            state_d = ST_WRITE;
            wr_mask = ~lane_wr_n;
        end
    end

    // State register and pipelined address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            addr_q  <= '0;
            live_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr;
            live_q  <= rd_en;
        end
    end

    // Outputs from the present state
    always_comb begin
        unique case (state_q)
            ST_READ:  rd_en = 1'b1;
            ST_WRITE: rd_en = 1'b0;
            default:  rd_en = 1'b0;
        endcase
    end

    assign rd_addr  = addr_q;
    assign out_live = live_q;

    a_r2_desel_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_any |=> !rd_en);
    a_r5_read_after_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ($past(wr_mask) == '0));
    a_r7_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !out_live);
    a_r6_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> out_live);
endmodule

// File: rtl/pss_array.sv
`timescale 1ns/1ps
module pss_array #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [LANE_W*LANES-1:0] wr_word,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANE_W*LANES-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (wr_mask[g]) begin
                lane_mem[wr_addr] <= wr_word[g*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (rd_en) begin
                lane_q <= lane_mem[rd_addr];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = lane_q;
    end

    a_r8_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_word));
endmodule

// File: rtl/pss_core.sv
`timescale 1ns/1ps
module pss_core #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    sel0_n,
    input  logic                    sel1,
    input  logic                    sel2_n,
    input  logic                    gwr_n,
    input  logic                    bwfn_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    oe_n,
    input  logic [LANE_W*LANES-1:0] wdata,
    output logic [LANE_W*LANES-1:0] rdata,
    output logic                    rvalid
);
    localparam int DATA_W = LANE_W * LANES;

    logic [LANES-1:0]  wr_mask;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic              live;
    logic [DATA_W-1:0] word;

    pss_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .sel0_n    (sel0_n),
        .sel1      (sel1),
        .sel2_n    (sel2_n),
        .gwr_n     (gwr_n),
        .bwfn_n    (bwfn_n),
        .lane_wr_n (lane_wr_n),
        .wr_mask   (wr_mask),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .out_live  (live)
    );

    pss_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) array_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_addr (addr),
        .wr_mask (wr_mask),
        .wr_word (wdata),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_word (word)
    );

    // Asynchronous output gating
    assign rdata  = oe_n ? '0 : word;
    assign rvalid = !oe_n && live;

    a_r9_oe_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!rvalid && (rdata == '0)));
endmodule

// File: tb/pss_core_tb.sv
`timescale 1ns/1ps
module pss_core_tb_top;
    localparam int ADDR_W = 6;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;
    localparam int NVEC   = 19;

    // sel field order: {sel0_n, sel1, sel2_n}; 3'b010 selects
    typedef struct packed {
        logic [2:0]        sel;
        logic              gw_n;
        logic              bf_n;
        logic [1:0]        ln_n;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] wd;
        logic              ev;
        logic [DATA_W-1:0] ed;
    } vec_t;

    // Expected values describe the outputs after this step's edge
    localparam vec_t TBL [NVEC] = '{
        '{3'b010, 1'b0, 1'b1, 2'b11, 6'd1, 18'h12345, 1'b0, 18'h00000}, // R3 write
        '{3'b010, 1'b0, 1'b1, 2'b11, 6'd2, 18'h0ABCD, 1'b0, 18'h00000}, // R3 write
        '{3'b010, 1'b1, 1'b1, 2'b11, 6'd1, 18'h00000, 1'b0, 18'h00000}, // read 1
        '{3'b010, 1'b1, 1'b1, 2'b11, 6'd2, 18'h00000, 1'b1, 18'h12345}, // R6 R10
        '{3'b010, 1'b1, 1'b0, 2'b10, 6'd1, 18'h3FFFF, 1'b1, 18'h0ABCD}, // R4 lane0
        '{3'b010, 1'b1, 1'b0, 2'b01, 6'd2, 18'h00000, 1'b0, 18'h0ABCD}, // R4 lane1, R8
        '{3'b010, 1'b1, 1'b1, 2'b11, 6'd1, 18'h00000, 1'b0, 18'h0ABCD},
        '{3'b010, 1'b1, 1'b1, 2'b11, 6'd2, 18'h00000, 1'b1, 18'h123FF}, // R4
        '{3'b010, 1'b1, 1'b1, 2'b00, 6'd1, 18'h00000, 1'b1, 18'h001CD}, // R5
        '{3'b010, 1'b1, 1'b0, 2'b11, 6'd2, 18'h00000, 1'b1, 18'h123FF}, // R5
        '{3'b000, 1'b0, 1'b1, 2'b11, 6'd1, 18'h00000, 1'b1, 18'h001CD}, // R2 R5
        '{3'b110, 1'b0, 1'b1, 2'b11, 6'd2, 18'h00000, 1'b0, 18'h001CD}, // R7
        '{3'b011, 1'b0, 1'b1, 2'b11, 6'd1, 18'h00000, 1'b0, 18'h001CD}, // R2
        '{3'b010, 1'b1, 1'b1, 2'b11, 6'd1, 18'h00000, 1'b0, 18'h001CD},
        '{3'b010, 1'b1, 1'b1, 2'b11, 6'd2, 18'h00000, 1'b1, 18'h123FF}, // R2
        '{3'b010, 1'b0, 1'b0, 2'b11, 6'd1, 18'h2AAAA, 1'b1, 18'h001CD}, // R3
        '{3'b010, 1'b1, 1'b1, 2'b11, 6'd1, 18'h00000, 1'b0, 18'h001CD}, // R7
        '{3'b111, 1'b1, 1'b1, 2'b11, 6'd0, 18'h00000, 1'b1, 18'h2AAAA}, // R10
        '{3'b111, 1'b1, 1'b1, 2'b11, 6'd0, 18'h00000, 1'b0, 18'h2AAAA}  // R7
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
    logic              gwr_n = 1'b1, bwfn_n = 1'b1, oe_n = 1'b0;
    logic [LANES-1:0]  lane_wr_n = '1;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              rvalid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pss_core #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel0_n(sel0_n), .sel1(sel1),
        .sel2_n(sel2_n), .gwr_n(gwr_n), .bwfn_n(bwfn_n), .lane_wr_n(lane_wr_n),
        .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic chk(input string req, input logic ev, input logic [DATA_W-1:0] ed);
        checks++;
        if (rvalid !== ev || rdata !== ed) begin
            errors++;
            $display("FAIL %s: rvalid=%0b rdata=%05h expected rvalid=%0b rdata=%05h",
                     req, rvalid, rdata, ev, ed);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R1: reset state
        #12;
        chk("R1 in reset", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 after release", 1'b0, '0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {sel0_n, sel1, sel2_n} = TBL[i].sel;
            gwr_n     = TBL[i].gw_n;
            bwfn_n    = TBL[i].bf_n;
            lane_wr_n = TBL[i].ln_n;
            addr      = TBL[i].a;
            wdata     = TBL[i].wd;
            @(posedge clk);
            #1;
            chk($sformatf("R2-R8,R10 table step %0d", i), TBL[i].ev, TBL[i].ed);
        end

        // R9: output enable gating without disturbing the pipeline
        @(negedge clk);
        {sel0_n, sel1, sel2_n} = 3'b010;
        gwr_n = 1'b1; bwfn_n = 1'b1; lane_wr_n = '1; addr = 6'd2;
        @(negedge clk);
        {sel0_n, sel1, sel2_n} = 3'b111;
        @(posedge clk);
        #1;
        chk("R9 enabled", 1'b1, 18'h001CD);
        oe_n = 1'b1;
        #1;
        chk("R9 disabled", 1'b0, '0);
        oe_n = 1'b0;
        #1;
        chk("R9 re-enabled", 1'b1, 18'h001CD);

        // R1: reset in mid-run clears the outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 mid-run reset", 1'b0, '0);
        finish_run();
    end
endmodule